// File: doc/BRIEF.md
# DRAM Refresh and Start-up Scheduler

This block decides when an asynchronous DRAM controller must spend a memory cycle on refresh. It does not drive any memory pins. Instead it raises a request toward the main cycle sequencer and waits for a grant. The sequencer then runs the refresh on the pins, either as a row-only refresh or as a column-before-row refresh.

After reset the block stays silent for a programmable power-up wait. It then asks for a fixed number of dummy refresh cycles, and after the last of them is granted it raises a ready flag. From then on a free-running interval timer adds one owed refresh every `REFRESH_PERIOD_CYCLES / 2**ROW_W` clocks, so that all rows are visited within the retention period. Owed refreshes are counted, up to a saturating limit, so that a late grant does not lose one.

A row counter supplies the address for row-only refreshes. It steps by one on each granted refresh. When the mode input selects the column-before-row style, the memory keeps its own row counter, so this counter is left alone.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and directly after it, `refReq` is 0, `memReady` is 0 and `refRow` is 0.
- R2: No request is raised during the power-up wait. The first request is high after rising edge `STARTUP_CYCLES + 1`, counted from the first edge with reset released.
- R3: Exactly `INIT_REFRESHES` accepted grants (`refReq` and `refGrant` both 1 at a rising edge) occur before `memReady`. `memReady` becomes 1 at the edge of the last of these grants.
- R4: `refReq` is 0 in the cycle after an accepted grant. If work remains, it is 1 again in the cycle after that.
- R5: After `memReady`, one refresh becomes owed every `REFRESH_PERIOD_CYCLES / 2**ROW_W` clocks, the first one that many clocks after `memReady` rises. `refReq` rises one edge after a refresh becomes owed.
- R6: The owed count saturates at `PEND_MAX`. A saturated backlog is served by `PEND_MAX` grants on alternate cycles once grants resume.
- R7: With `cbrMode` = 0, `refRow` increases by one on every accepted grant, including the start-up grants, and wraps from 2**ROW_W-1 to 0.
- R8: With `cbrMode` = 1, an accepted grant leaves `refRow` unchanged.
- R9: `refGrant` has no effect while `refReq` is 0. The owed count, the row and the start-up progress are all unchanged.
- R10: Once `memReady` is 1 it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cbrMode | input | 1 | 1: refresh uses the memory's internal row counter; 0: row-only refresh using `refRow` |
| refGrant | input | 1 | Sequencer accepts the pending request at this edge |
| refReq | output | 1 | A refresh cycle is wanted |
| memReady | output | 1 | Start-up sequence complete |
| refRow | output | ROW_W | Row to refresh in row-only mode |

## Verification
Every output is registered. The first request is due one edge after the power-up wait ends. The request drops on the edge that accepts a grant, and `memReady` rises on the edge of the last start-up grant. A newly owed refresh appears as a request one edge after the interval timer wraps. A behavioural model advances on each rising edge from the same grant and mode values the design sees. The bench compares it with the outputs at the following falling edge, so each result is sampled in the cycle it is due. Targeted checks count edges since reset release, count accepted grants over whole intervals, and watch the row across a wrap and across a mode switch.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_INIT = 2'd1,
    PH_RUN  = 2'd2
  } phase_e;

  // control -> datapath
  typedef struct packed {
    logic waitCount;
    logic initCount;
    logic runTimer;
    logic takeOwed;
    logic advanceRow;
  } strobe_s;

  // datapath -> control
  typedef struct packed {
    logic waitDone;
    logic initLast;
    logic owed;
  } status_s;

endpackage

// File: rtl/refresh_datapath.sv
module refresh_datapath
  import refresh_pkg::*;
#(
  parameter int STARTUP_CYCLES = 50000,
  parameter int INIT_REFRESHES = 8,
  parameter int ROW_W          = 10,
  parameter int INTERVAL       = 3906,
  parameter int PEND_MAX       = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_s          strobe,
  output status_s          stat,
  output logic [ROW_W-1:0] rowAddr
);

  localparam int WAIT_W  = $clog2(STARTUP_CYCLES + 1);
  localparam int INIT_W  = $clog2(INIT_REFRESHES + 1);
  localparam int TIMER_W = $clog2(INTERVAL + 1);
  localparam int PEND_W  = $clog2(PEND_MAX + 1);

  logic [WAIT_W-1:0]  waitCnt;
  logic [INIT_W-1:0]  initCnt;
  logic [TIMER_W-1:0] timerQ;
  logic [PEND_W-1:0]  pendQ;
  logic               tick;

  assign tick          = strobe.runTimer && (timerQ == TIMER_W'(INTERVAL - 1));
  assign stat.waitDone = strobe.waitCount && (waitCnt == WAIT_W'(STARTUP_CYCLES - 1));
  assign stat.initLast = (initCnt == INIT_W'(INIT_REFRESHES - 1));
  assign stat.owed     = (pendQ != '0);

  // power-up wait counter
  always_ff @(posedge clk) begin
    if (!rstN)                 waitCnt <= '0;
    else if (strobe.waitCount) waitCnt <= waitCnt + 1'b1;
  end

  // start-up refresh counter
  always_ff @(posedge clk) begin
    if (!rstN)                 initCnt <= '0;
    else if (strobe.initCount) initCnt <= initCnt + 1'b1;
  end

  // refresh interval timer
  always_ff @(posedge clk) begin
    if (!rstN)                timerQ <= '0;
    else if (tick)            timerQ <= '0;
    else if (strobe.runTimer) timerQ <= timerQ + 1'b1;
  end

  // owed refresh count, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
    end else begin
      unique case ({tick, strobe.takeOwed})
        2'b10:   if (pendQ != PEND_W'(PEND_MAX)) pendQ <= pendQ + 1'b1;
        2'b01:   pendQ <= pendQ - 1'b1;
        default: pendQ <= pendQ;
      endcase
    end
  end

  // row counter for row-only refresh
  always_ff @(posedge clk) begin
    if (!rstN)                  rowAddr <= '0;
    else if (strobe.advanceRow) rowAddr <= rowAddr + 1'b1;
  end

  // R6
  pend_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ == PEND_W'(PEND_MAX) && tick && !strobe.takeOwed) |=> (pendQ == PEND_W'(PEND_MAX)));

  // R7
  row_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advanceRow |=> (rowAddr == $past(rowAddr) + 1'b1));

  // R8
  row_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advanceRow |=> $stable(rowAddr));

endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    refGrant,
  input  logic    cbrMode,
  input  status_s stat,
  output strobe_s strobe,
  output logic    refReq,
  output logic    memReady
);

  phase_e phaseQ, phaseD;
  logic   accept;
  logic   wantWork;

  assign accept   = refReq && refGrant;
  assign wantWork = (phaseQ == PH_INIT) || (phaseQ == PH_RUN && stat.owed);
  assign memReady = (phaseQ == PH_RUN);

  always_comb begin
    strobe.waitCount  = (phaseQ == PH_WAIT);
    strobe.initCount  = (phaseQ == PH_INIT) && accept;
    strobe.runTimer   = (phaseQ == PH_RUN);
    strobe.takeOwed   = (phaseQ == PH_RUN) && accept;
    strobe.advanceRow = accept && !cbrMode;
  end

  always_comb begin
    phaseD = phaseQ;
    unique case (phaseQ)
      PH_WAIT: if (stat.waitDone)           phaseD = PH_INIT;
      PH_INIT: if (accept && stat.initLast) phaseD = PH_RUN;
      default: phaseD = phaseQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_WAIT;
      refReq <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      refReq <= wantWork && !accept;
    end
  end

  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && refGrant) |=> !refReq);

  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReady |=> memReady);

  // R2
  quiet_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> (phaseQ != PH_WAIT));

  // R9
  idle_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!refReq && phaseQ == PH_INIT) |=> (phaseQ == PH_INIT));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import refresh_pkg::*;
#(
  parameter int STARTUP_CYCLES        = 50000,
  parameter int INIT_REFRESHES        = 8,
  parameter int ROW_W                 = 10,
  parameter int REFRESH_PERIOD_CYCLES = 4000000,
  parameter int PEND_MAX              = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cbrMode,
  input  logic             refGrant,
  output logic             refReq,
  output logic             memReady,
  output logic [ROW_W-1:0] refRow
);

  localparam int INTERVAL = REFRESH_PERIOD_CYCLES / (1 << ROW_W);

  strobe_s strobe;
  status_s stat;

  refresh_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .refGrant (refGrant),
    .cbrMode  (cbrMode),
    .stat     (stat),
    .strobe   (strobe),
    .refReq   (refReq),
    .memReady (memReady)
  );

  refresh_datapath #(
    .STARTUP_CYCLES (STARTUP_CYCLES),
    .INIT_REFRESHES (INIT_REFRESHES),
    .ROW_W          (ROW_W),
    .INTERVAL       (INTERVAL),
    .PEND_MAX       (PEND_MAX)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .stat    (stat),
    .rowAddr (refRow)
  );

endmodule

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;

  localparam int S    = 20;
  localparam int NI   = 8;
  localparam int RW   = 10;
  localparam int IV   = 16;
  localparam int PM   = 3;
  localparam int NROW = 1 << RW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cbrMode = 1'b0;
  logic          refGrant = 1'b0;
  logic          refReq, memReady;
  logic [RW-1:0] refRow;

  int errors = 0, checks = 0;
  int gMode = 1;               // 0 withhold, 1 always, 2 pseudo-random
  int lfsr = 32'h1ACE5;
  int cyc = 0;
  int accCount = 0;
  bit lastAcc = 0, sawReq = 0, sawWrap = 0, done = 0;
  int prevRow = 0;

  // behavioural reference model
  int mPhase = 0, mWait = 0, mInit = 0, mTimer = 0, mPend = 0, mRow = 0;
  bit mReq = 0, mEverReady = 0;

  always #2 clk = ~clk;

  dram_refresh_sched #(
    .STARTUP_CYCLES(S), .INIT_REFRESHES(NI), .ROW_W(RW),
    .REFRESH_PERIOD_CYCLES(IV * NROW), .PEND_MAX(PM)
  ) u0 (
    .clk(clk), .rstN(rstN), .cbrMode(cbrMode), .refGrant(refGrant),
    .refReq(refReq), .memReady(memReady), .refRow(refRow)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mWait = 0; mInit = 0; mTimer = 0; mPend = 0; mRow = 0; mReq = 0;
      cyc = 0;
    end else begin
      bit acc, want, tk;
      cyc++;
      acc  = mReq && refGrant;
      want = (mPhase == 1) || (mPhase == 2 && mPend > 0);
      if (acc && !cbrMode) mRow = (mRow + 1) % NROW;
      if (mPhase == 0) begin
        if (mWait == S - 1) mPhase = 1; else mWait++;
      end else if (mPhase == 1) begin
        if (acc) begin mInit++; if (mInit == NI) mPhase = 2; end
      end else begin
        tk = (mTimer == IV - 1);
        mTimer = tk ? 0 : mTimer + 1;
        mPend = mPend + int'(tk) - int'(acc);
        if (mPend > PM) mPend = PM;
      end
      mReq = want && !acc;
      if (mPhase == 2) mEverReady = 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", req, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      string rq;
      @(negedge clk);
      if (!rstN) rq = "R1";
      else if (mPhase == 0) rq = "R2";
      else if (mPhase == 1) rq = "R3";
      else if (mPend == PM) rq = "R6";
      else rq = "R5";
      check(refReq === mReq, rq, int'(refReq), int'(mReq));
      check(memReady === (mPhase == 2), mEverReady ? "R10" : "R3", int'(memReady), int'(mPhase == 2));
      check(refRow === RW'(mRow), cbrMode ? "R8" : "R7", int'(refRow), mRow);
      if (lastAcc) check(refReq === 1'b0, "R4", int'(refReq), 0);
      if (rstN && !sawReq && refReq) begin
        sawReq = 1;
        check(cyc == S + 1, "R2", cyc, S + 1);
      end
      if (rstN && prevRow == NROW - 1 && refRow == 0) sawWrap = 1;
      prevRow = int'(refRow);
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
      case (gMode)
        0: refGrant = 1'b0;
        1: refGrant = 1'b1;
        default: refGrant = lfsr[3] & lfsr[7];
      endcase
      lastAcc = rstN && refReq && refGrant;
      if (lastAcc) accCount++;
    end
  endtask

  initial begin
    int r0, a0;
    gMode = 1;
    step(3);
    // R1: reset state
    check(refReq === 1'b0 && memReady === 1'b0 && refRow === '0, "R1", int'(refReq) + int'(memReady), 0);
    rstN = 1'b1;
    // R9: grant held high all through the power-up wait
    step(S - 1);
    check(refReq === 1'b0 && refRow === '0, "R9", int'(refRow), 0);
    // R3: count grants until ready
    accCount = 0;
    while (!memReady && cyc < S + 4 * NI + 10) step(1);
    check(accCount == NI, "R3", accCount, NI);
    check(memReady === 1'b1, "R3", int'(memReady), 1);
    // R5: one grant per interval in steady state
    step(2 * IV);
    accCount = 0;
    step(10 * IV);
    check(accCount == 10, "R5", accCount, 10);
    // R6: backlog saturates, then drains on alternate cycles
    gMode = 0;
    step(8 * IV);
    gMode = 1;
    accCount = 0;
    step(6);
    check(accCount == PM, "R6", accCount, PM);
    // irregular grants
    gMode = 2;
    step(20 * IV);
    // R8: column-before-row mode leaves the row alone
    gMode = 1;
    step(2 * IV);
    cbrMode = 1'b1;
    r0 = int'(refRow);
    a0 = accCount;
    step(6 * IV);
    check(accCount > a0, "R8", accCount - a0, 6);
    check(int'(refRow) == r0, "R8", int'(refRow), r0);
    cbrMode = 1'b0;
    // R7: row wraps after a full sweep
    step((NROW + 8) * IV);
    check(sawWrap, "R7", int'(sawWrap), 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule